// File: doc/BRIEF.md
# 4B/5B Transmit Code-Group Encoder

This block turns a nibble-wide transmit stream into 5-bit code groups, one code group per clock. The inputs are a 4-bit nibble, a transmit enable and a transmit error. It frames each transmission with delimiter pairs. A start pair goes out when transmit enable goes high, and it takes the place of the first two nibbles presented. An end pair goes out when transmit enable goes low. Between frames the block sends idle continuously.

While a frame is in progress, a high transmit error replaces that cycle's data code group with the error symbol. Outside a frame, transmit error is ignored. The output is registered, so each code group appears one clock after the inputs that produced it. A synchronous reset returns the block to idle and abandons any frame in progress.

Downstream stages take the code groups unchanged: scrambler, serializer and line coder. MAC framing happens upstream.

Top module: `txcg_encoder`

## Requirements
- R1: Inside a frame, with transmit error low, nibble n is sent as the code group at index n of this list, for n = 0x0 up to 0xF: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R2: When transmit enable is high while the block is idle, the block sends 11000 and then 10001. These two code groups take the place of the first two nibbles presented.
- R3: When transmit enable is low during a frame, the block sends 01101 in that cycle and 00111 in the next.
- R4: After 00111, the block sends idle 11111 in every cycle until transmit enable is high again.
- R5: Inside a frame, a high transmit error makes the block send 00100 in place of that cycle's data code group.
- R6: The code group produced from the inputs sampled at rising edge k is visible on the output from edge k onward, and the block produces exactly one code group per clock.
- R7: When transmit enable is high during the cycle in which 00111 is being produced, 00111 is still sent. The start pair 11000, 10001 follows directly after it.
- R8: While the block is idle and transmit enable is low, transmit error has no effect, and the output stays 11111.
- R9: While the synchronous reset is high, the output is 11111. After reset is released, the block is idle, even if a frame was in progress.
- R10: The code groups 10001 and 00111 are always sent in the cycle after 11000 and 01101 respectively, whatever the transmit enable and transmit error inputs are in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one code group per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable; high marks a frame |
| tx_er | input | 1 | Transmit error; replaces data with the error symbol |
| txd | input | 4 | Transmit nibble |
| code | output | 5 | Registered 5-bit code group |

## Verification
A frame carrying all sixteen nibbles in order separates the mapping of each value and shows that the first two nibbles are replaced by the start pair. Error pulses inside a frame and during idle distinguish substitution from suppression. A one-cycle frame, and a frame restarted during the end pair, show that delimiters are never shortened or merged. A reset in mid-frame shows that the sequencer really returns to idle, not only the output register.

// File: rtl/txcg_pkg.sv
package txcg_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 5;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [NIB_W-1:0]  nib_t;

  localparam code_t CG_IDLE = 5'b11111;
  localparam code_t CG_J    = 5'b11000;
  localparam code_t CG_K    = 5'b10001;
  localparam code_t CG_T    = 5'b01101;
  localparam code_t CG_R    = 5'b00111;
  localparam code_t CG_H    = 5'b00100;

  typedef enum logic [1:0] {ST_IDLE, ST_SSD, ST_DATA, ST_ESD} seq_state_e;
  typedef enum logic [2:0] {SEL_IDLE, SEL_J, SEL_K, SEL_DATA, SEL_ERR, SEL_T, SEL_R} sel_e;

  function automatic code_t nib_to_code(input nib_t n);
    code_t c;
    case (n)
      4'h0: c = 5'b11110;
      4'h1: c = 5'b01001;
      4'h2: c = 5'b10100;
      4'h3: c = 5'b10101;
      4'h4: c = 5'b01010;
      4'h5: c = 5'b01011;
      4'h6: c = 5'b01110;
      4'h7: c = 5'b01111;
      4'h8: c = 5'b10010;
      4'h9: c = 5'b10011;
      4'hA: c = 5'b10110;
      4'hB: c = 5'b10111;
      4'hC: c = 5'b11010;
      4'hD: c = 5'b11011;
      4'hE: c = 5'b11100;
      default: c = 5'b11101;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/txcg_nibble_map.sv
module txcg_nibble_map
  import txcg_pkg::*;
(
  input  nib_t  nib,
  output code_t cg
);
  assign cg = nib_to_code(nib);
endmodule

// File: rtl/txcg_frame_seq.sv
module txcg_frame_seq
  import txcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_en,
  input  logic       tx_er,
  output sel_e       sel,
  output seq_state_e state
);
  seq_state_e st_nx;

  // named events for the checks
  logic sof_evt, eof_evt;
  assign sof_evt = (sel == SEL_J);
  assign eof_evt = (sel == SEL_T);

  always_comb begin
    sel   = SEL_IDLE;
    st_nx = state;
    case (state)
      ST_IDLE: begin
        if (tx_en) begin
          sel   = SEL_J;
          st_nx = ST_SSD;
        end
      end
      ST_SSD: begin
        sel   = SEL_K;
        st_nx = ST_DATA;
      end
      ST_DATA: begin
        if (!tx_en) begin
          sel   = SEL_T;
          st_nx = ST_ESD;
        end else if (tx_er) begin
          sel = SEL_ERR;
        end else begin
          sel = SEL_DATA;
        end
      end
      default: begin
        sel   = SEL_R;
        st_nx = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= st_nx;
  end

  AST_J_THEN_K: assert property (@(posedge clk) disable iff (rst)
    sof_evt |=> (sel == SEL_K)); // R2
  AST_T_THEN_R: assert property (@(posedge clk) disable iff (rst)
    eof_evt |=> (sel == SEL_R)); // R3
  AST_ERR_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_ERR) |-> (state == ST_DATA)); // R8
endmodule

// File: rtl/txcg_encoder.sv
module txcg_encoder
  import txcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  output logic [4:0] code
);
  sel_e       sel;
  seq_state_e seq_st;
  code_t      data_cg;
  code_t      next_cg;

  txcg_nibble_map u_map (
    .nib (txd),
    .cg  (data_cg)
  );

  txcg_frame_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .tx_en (tx_en),
    .tx_er (tx_er),
    .sel   (sel),
    .state (seq_st)
  );

  always_comb begin
    case (sel)
      SEL_J:    next_cg = CG_J;
      SEL_K:    next_cg = CG_K;
      SEL_DATA: next_cg = data_cg;
      SEL_ERR:  next_cg = CG_H;
      SEL_T:    next_cg = CG_T;
      SEL_R:    next_cg = CG_R;
      default:  next_cg = CG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) code <= CG_IDLE;
    else     code <= next_cg;
  end

  AST_ERR_TO_H: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_ERR) |=> (code == CG_H)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (seq_st == ST_IDLE && !tx_en) |=> (code == CG_IDLE)); // R4
  AST_R_THEN_J_OR_I: assert property (@(posedge clk) disable iff (rst)
    (code == CG_R) |=> (code == CG_J || code == CG_IDLE)); // R7
  AST_DATA_MAPPED: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_DATA) |=> (code != CG_IDLE && code != CG_H)); // R1
endmodule

// File: tb/txcg_encoder_bench.sv
module txcg_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [79:0] MAP = {5'b11101, 5'b11100, 5'b11011, 5'b11010,
                                 5'b10111, 5'b10110, 5'b10011, 5'b10010,
                                 5'b01111, 5'b01110, 5'b01011, 5'b01010,
                                 5'b10101, 5'b10100, 5'b01001, 5'b11110};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic [4:0] code;

  int n_run = 0, n_fail = 0;
  int phase = 0; // 0 idle, 1 after J, 2 in frame, 3 after T
  bit done = 0;
  logic [4:0] exp_q[$];
  string tag_q[$];

  txcg_encoder u_txcg_encoder (.clk(clk), .rst(rst), .tx_en(tx_en), .tx_er(tx_er),
                               .txd(txd), .code(code));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic push(input logic [4:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic do_reset(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      rst = 1'b1; tx_en = 1'b0; tx_er = 1'b0;
      push(5'b11111, "R9 reset idle");
      phase = 0;
    end
  endtask

  task automatic drive(input logic en, input logic er, input logic [3:0] d);
    @(negedge clk);
    rst = 1'b0; tx_en = en; tx_er = er; txd = d;
    case (phase)
      0: if (en) begin push(5'b11000, "R2 start J"); phase = 1; end
         else if (er) push(5'b11111, "R8 error ignored when idle");
         else push(5'b11111, "R4 idle");
      1: begin push(5'b10001, (en && !er) ? "R2 start K" : "R10 K forced"); phase = 2; end
      2: if (!en) begin push(5'b01101, "R3 end T"); phase = 3; end
         else if (er) push(5'b00100, "R5 error symbol");
         else push(MAP[d*5 +: 5], "R1 R6 data map");
      default: begin push(5'b00111, en ? "R7 R kept on restart" : "R3 end R"); phase = 0; end
    endcase
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if (code !== e) begin
          n_fail++;
          $display("FAIL %s: got %b expected %b at %0t", t, code, e, $time);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stimulus
    do_reset(3);                                 // R9
    for (int i = 0; i < 3; i++) drive(0, 0, 4'h5); // R4
    drive(0, 1, 4'h3); drive(0, 1, 4'hC);        // R8
    // full frame: two replaced nibbles then all 16 values (R1, R2, R6)
    drive(1, 0, 4'h5); drive(1, 0, 4'h5);
    for (int n = 0; n < 16; n++) drive(1, 0, 4'(n));
    drive(0, 0, 4'h0); drive(0, 0, 4'h0);        // R3
    for (int i = 0; i < 3; i++) drive(0, 0, 4'h0); // R4
    // frame with error pulses (R5), error during K (R10)
    drive(1, 0, 4'h5); drive(1, 1, 4'h5);
    drive(1, 0, 4'hA); drive(1, 1, 4'hA); drive(1, 1, 4'h0); drive(1, 0, 4'h7);
    drive(0, 1, 4'h0); drive(0, 1, 4'h0); drive(0, 1, 4'h0); // T, R, then R8
    // one-cycle enable: J, K forced, T, R (R10, R3)
    drive(1, 0, 4'h5); drive(0, 0, 4'h0); drive(0, 0, 4'h0); drive(0, 0, 4'h0);
    drive(0, 0, 4'h0);
    // restart during end pair (R7)
    drive(1, 0, 4'h5); drive(1, 0, 4'h5); drive(1, 0, 4'h9);
    drive(0, 0, 4'h0); drive(1, 0, 4'h5); drive(1, 0, 4'h5); drive(1, 0, 4'h5);
    drive(1, 0, 4'h2);
    // reset mid-frame returns to idle (R9)
    do_reset(1);
    drive(0, 0, 4'h0); drive(0, 0, 4'h0);
    drive(1, 0, 4'h5); drive(1, 0, 4'h5); drive(1, 0, 4'hE); drive(0, 0, 4'h0);
    drive(0, 0, 4'h0); drive(0, 0, 4'h0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule